// File: doc/BRIEF.md
# GPIO Input Deglitch Filter

This block cleans up one asynchronous GPIO input before the rest of the pin logic uses it for status reads and interrupt detection. The raw pin first passes through a two-flop synchronizer. The synchronized level then feeds a filter that accepts a change only after the input has held the new value for a programmable time. Time is measured in ticks of a slow real-time enable, and the tick runs in the block's clock domain. The timeout is the product of a four-bit count and one of four units: 2, 8, 512 or 2048 ticks. Two select bits choose the unit.

A two-bit mode input selects one of four filter types. With mode 0 there is no filtering. Mode 1 filters both edges. The other two modes each let glitches of one polarity pass through at once and filter only the return edge. Mode 2 preserves low pulses. Mode 3 preserves high pulses. The block outputs both the synchronized raw level and the filtered level. The configuration inputs are static fields that an enclosing register block provides.

Top module: `gpio_deglitch`

## Requirements
- R1: `level_sync_o` equals the value `pin_i` had two rising clock edges earlier, because it passes through a two-stage synchronizer.
- R2: While `rst_n` is low, both outputs are 0 and no transition is pending. A reset in the middle of operation clears a filtered level of 1 at once.
- R3: With `mode_i` = 0 (bypass), `level_filt_o` takes the value of `level_sync_o` one clock later, for either edge.
- R4: With `mode_i` = 1 (filter both edges), a change of `level_sync_o` reaches `level_filt_o` only after the input has stayed at the new value for count × unit ticks in a row. The output updates on the clock edge that consumes the last of those ticks.
- R5: The unit is selected by `{scale_coarse_i, scale_step_i}`: 00 gives 2 ticks, 01 gives 8 ticks, 10 gives 512 ticks and 11 gives 2048 ticks.
- R6: With filtering active, a `count_i` of 0 gives a timeout of one unit.
- R7: If the synchronized input returns to the current filtered level before the timeout ends, the progress is discarded. A later change must then wait the full timeout again.
- R8: With `mode_i` = 2 (keep low pulses), a falling edge reaches the filtered output one clock after `level_sync_o`, even for a one-cycle low pulse. A rising edge is filtered as in R4.
- R9: With `mode_i` = 3 (keep high pulses), a rising edge reaches the filtered output one clock after `level_sync_o`. A falling edge is filtered as in R4.
- R10: Only clock cycles with `tick_i` high advance the timeout. Cycles without a tick leave the progress unchanged.
- R11: `level_filt_o` only ever changes to the value that `level_sync_o` had in the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Slow time-base enable, one clock wide per tick |
| pin_i | input | 1 | Asynchronous raw pin level |
| mode_i | input | 2 | Filter type: 0 bypass, 1 both edges, 2 keep low pulses, 3 keep high pulses |
| scale_coarse_i | input | 1 | Upper unit-select bit |
| scale_step_i | input | 1 | Lower unit-select bit |
| count_i | input | CNT_W (4) | Number of units in the timeout, 0 treated as 1 |
| level_sync_o | output | 1 | Synchronized raw level |
| level_filt_o | output | 1 | Filtered level |

## Verification
The bench keeps the default parameters. These are two synchronizer stages, a four-bit count and the real units of 2, 8, 512 and 2048 ticks. Because of this, each unit select is measured to the exact clock edge, and so is the longest timeout of 15 × 2048 ticks, with the tick held high. A second run divides the tick by three. It brackets the acceptance edge between the earliest and latest possible tick phase, which shows that cycles without a tick are not counted. Short bounces around the threshold show that a restart discards progress, and that one-cycle pulses of the preserved polarity still reach the output.

// File: rtl/gdb_pkg.sv
package gdb_pkg;

    typedef enum logic [1:0] {
        MODE_BYPASS    = 2'd0,
        MODE_BOTH      = 2'd1,
        MODE_KEEP_LOW  = 2'd2,
        MODE_KEEP_HIGH = 2'd3
    } gdb_mode_e;

endpackage

// File: rtl/gdb_sync.sv
module gdb_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

    // R1: every stage holds what the stage before it held one edge earlier
    for (genvar g = 1; g < STAGES; g++) begin : g_stage_chk
        a_r1_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
            chain_q[g] == $past(chain_q[g-1]));
    end

endmodule

// File: rtl/gdb_timebase.sv
module gdb_timebase #(
    parameter int UNIT_A = 2,
    parameter int UNIT_B = 8,
    parameter int UNIT_C = 512,
    parameter int UNIT_D = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       clear_i,
    input  logic [1:0] sel_i,
    output logic       unit_done_o
);

    localparam int MAX_AB = (UNIT_A > UNIT_B) ? UNIT_A : UNIT_B;
    localparam int MAX_CD = (UNIT_C > UNIT_D) ? UNIT_C : UNIT_D;
    localparam int MAX_U  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int PW     = $clog2(MAX_U + 1);

    localparam logic [PW-1:0] LAST_A = PW'(UNIT_A - 1);
    localparam logic [PW-1:0] LAST_B = PW'(UNIT_B - 1);
    localparam logic [PW-1:0] LAST_C = PW'(UNIT_C - 1);
    localparam logic [PW-1:0] LAST_D = PW'(UNIT_D - 1);

    typedef struct packed {
        logic [PW-1:0] presc;
    } tb_state_t;

    tb_state_t     st_d, st_q;
    logic [PW-1:0] last;

    always_comb begin
        case (sel_i)
            2'b00:   last = LAST_A;
            2'b01:   last = LAST_B;
            2'b10:   last = LAST_C;
            default: last = LAST_D;
        endcase

        st_d        = st_q;
        unit_done_o = 1'b0;
        if (clear_i) begin
            st_d.presc = '0;
        end else if (tick_i) begin
            if (st_q.presc >= last) begin
                st_d.presc  = '0;
                unit_done_o = 1'b1;
            end else begin
                st_d.presc = st_q.presc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10: a cycle with no tick and no restart leaves the prescaler untouched
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clear_i) |=> $stable(st_q.presc));

    // R7: a restart request empties the prescaler on the next edge
    a_r7_presc_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.presc == '0));

endmodule

// File: rtl/gdb_judge.sv
module gdb_judge
    import gdb_pkg::*;
#(
    parameter int   CNT_W   = 4,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  gdb_mode_e        mode_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             sync_i,
    input  logic             unit_done_i,
    output logic             clear_o,
    output logic             filt_o
);

    typedef struct packed {
        logic             filt;
        logic [CNT_W-1:0] units;
    } jd_state_t;

    jd_state_t        st_d, st_q;
    logic [CNT_W-1:0] target;
    logic             pass_now;

    always_comb begin
        target   = (count_i == '0) ? CNT_W'(1) : count_i;
        pass_now = ((mode_i == MODE_KEEP_LOW)  && !sync_i) ||
                   ((mode_i == MODE_KEEP_HIGH) &&  sync_i);

        st_d    = st_q;
        clear_o = 1'b1;
        if (mode_i == MODE_BYPASS) begin
            st_d.filt  = sync_i;
            st_d.units = '0;
        end else if (sync_i == st_q.filt) begin
            st_d.units = '0;
        end else if (pass_now) begin
            st_d.filt  = sync_i;
            st_d.units = '0;
        end else begin
            clear_o = 1'b0;
            if (unit_done_i) begin
                if (({1'b0, st_q.units} + 1'b1) >= {1'b0, target}) begin
                    st_d.filt  = sync_i;
                    st_d.units = '0;
                end else begin
                    st_d.units = st_q.units + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.filt  <= RST_VAL;
            st_q.units <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign filt_o = st_q.filt;

    // R3: in bypass the filtered level is the synchronized level one edge later
    a_r3_bypass_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_BYPASS) |=> (st_q.filt == $past(sync_i)));

    // R8: low level passes straight through when low pulses are kept
    a_r8_low_passes: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == MODE_KEEP_LOW) && !sync_i) |=> !st_q.filt);

    // R9: high level passes straight through when high pulses are kept
    a_r9_high_passes: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == MODE_KEEP_HIGH) && sync_i) |=> st_q.filt);

    // R7: agreement between input and output throws away counted units
    a_r7_units_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i == st_q.filt) |=> (st_q.units == '0));

    // R4: in two-sided filtering nothing moves the output without a finished unit
    a_r4_hold_without_unit: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == MODE_BOTH) && !unit_done_i) |=> $stable(st_q.filt));

    // R11: the output only ever adopts the previous synchronized level
    a_r11_from_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.filt != $past(st_q.filt)) |-> (st_q.filt == $past(sync_i)));

endmodule

// File: rtl/gpio_deglitch.sv
module gpio_deglitch
    import gdb_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter int   CNT_W       = 4,
    parameter int   UNIT_A      = 2,
    parameter int   UNIT_B      = 8,
    parameter int   UNIT_C      = 512,
    parameter int   UNIT_D      = 2048,
    parameter logic RST_LEVEL   = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             pin_i,
    input  logic [1:0]       mode_i,
    input  logic             scale_coarse_i,
    input  logic             scale_step_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             level_sync_o,
    output logic             level_filt_o
);

    gdb_mode_e mode;
    logic      sync_lvl;
    logic      restart;
    logic      unit_done;

    assign mode = gdb_mode_e'(mode_i);

    gdb_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (RST_LEVEL)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (sync_lvl)
    );

    gdb_timebase #(
        .UNIT_A (UNIT_A),
        .UNIT_B (UNIT_B),
        .UNIT_C (UNIT_C),
        .UNIT_D (UNIT_D)
    ) u_timebase (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .clear_i     (restart),
        .sel_i       ({scale_coarse_i, scale_step_i}),
        .unit_done_o (unit_done)
    );

    gdb_judge #(
        .CNT_W   (CNT_W),
        .RST_VAL (RST_LEVEL)
    ) u_judge (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .count_i     (count_i),
        .sync_i      (sync_lvl),
        .unit_done_i (unit_done),
        .clear_o     (restart),
        .filt_o      (level_filt_o)
    );

    assign level_sync_o = sync_lvl;

    // R2: reset leaves both levels at the reset value
    a_r2_reset_levels: assert property (@(posedge clk)
        !rst_n |-> (level_filt_o == RST_LEVEL && level_sync_o == RST_LEVEL));

endmodule

// File: tb/gpio_deglitch_tb.sv
module gpio_deglitch_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 9;

    typedef struct packed {
        logic [1:0]  mode;
        logic        coarse;
        logic        step;
        logic [3:0]  cnt;
        int unsigned d_rise;
        int unsigned d_fall;
    } vec_t;

    // delay = clock edges from pin drive to filtered change, tick every cycle:
    // 3 for bypass / immediate, 2 + count*unit otherwise
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 1'b0, 1'b0, 4'd0,  3,     3},      // R3 bypass
        '{2'd1, 1'b0, 1'b0, 4'd3,  8,     8},      // R4 R5 unit 2
        '{2'd1, 1'b0, 1'b1, 4'd2,  18,    18},     // R5 unit 8
        '{2'd1, 1'b1, 1'b0, 4'd1,  514,   514},    // R5 unit 512
        '{2'd1, 1'b1, 1'b1, 4'd0,  2050,  2050},   // R6 count zero, unit 2048
        '{2'd2, 1'b0, 1'b0, 4'd5,  12,    3},      // R8 keep low
        '{2'd3, 1'b0, 1'b1, 4'd1,  3,     10},     // R9 keep high
        '{2'd1, 1'b0, 1'b0, 4'd15, 32,    32},     // R4 max count
        '{2'd1, 1'b1, 1'b1, 4'd15, 30722, 30722}   // R5 longest timeout
    };
    localparam string TAGS [NVEC] = '{"R3", "R5", "R5", "R5", "R6", "R8", "R9", "R4", "R5"};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       pin = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       coarse = 1'b0;
    logic       step = 1'b0;
    logic [3:0] cnt = 4'd0;
    logic       lvl_sync, lvl_filt;

    int tick_div = 1;
    int div_cnt  = 0;
    int errors   = 0;
    int checks   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (div_cnt >= tick_div - 1) begin
            div_cnt <= 0;
            tick    <= 1'b1;
        end else begin
            div_cnt <= div_cnt + 1;
            tick    <= 1'b0;
        end
    end

    gpio_deglitch u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_i         (tick),
        .pin_i          (pin),
        .mode_i         (mode),
        .scale_coarse_i (coarse),
        .scale_step_i   (step),
        .count_i        (cnt),
        .level_sync_o   (lvl_sync),
        .level_filt_o   (lvl_filt)
    );

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic settle_low();
        mode = 2'd0;
        pin  = 1'b0;
        wait_neg(4);
    endtask

    task automatic edge_case(input string tag, input logic val, input int unsigned dly);
        pin = val;
        wait_neg(int'(dly) - 1);
        chk(tag, "before timeout", lvl_filt, ~val);
        wait_neg(1);
        chk(tag, "at timeout", lvl_filt, val);
    endtask

    initial begin
        wait_neg(3);
        // R2: reset state
        chk("R2", "filt in reset", lvl_filt, 1'b0);
        chk("R2", "sync in reset", lvl_sync, 1'b0);
        rst_n = 1'b1;
        wait_neg(2);
        chk("R2", "filt after reset", lvl_filt, 1'b0);

        // R1: two-stage synchronizer latency
        pin = 1'b1;
        wait_neg(1);
        chk("R1", "sync after one edge", lvl_sync, 1'b0);
        wait_neg(1);
        chk("R1", "sync after two edges", lvl_sync, 1'b1);
        settle_low();

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            settle_low();
            mode   = VECS[i].mode;
            coarse = VECS[i].coarse;
            step   = VECS[i].step;
            cnt    = VECS[i].cnt;
            wait_neg(1);
            edge_case(TAGS[i], 1'b1, VECS[i].d_rise);
            edge_case(TAGS[i], 1'b0, VECS[i].d_fall);
        end

        // R7: bounce back restarts the full timeout (unit 2, count 3 -> 6 ticks)
        settle_low();
        mode = 2'd1; coarse = 1'b0; step = 1'b0; cnt = 4'd3;
        wait_neg(1);
        pin = 1'b1;
        wait_neg(4);
        pin = 1'b0;
        wait_neg(1);
        pin = 1'b1;
        wait_neg(7);
        chk("R7", "restarted count not done", lvl_filt, 1'b0);
        wait_neg(1);
        chk("R7", "restarted count done", lvl_filt, 1'b1);

        // R8: short high pulse is removed, one-cycle low pulse is kept
        settle_low();
        mode = 2'd2; coarse = 1'b0; step = 1'b0; cnt = 4'd5;
        wait_neg(1);
        pin = 1'b1;
        wait_neg(3);
        pin = 1'b0;
        wait_neg(12);
        chk("R8", "short high pulse removed", lvl_filt, 1'b0);
        pin = 1'b1;
        wait_neg(14);
        chk("R8", "long high accepted", lvl_filt, 1'b1);
        pin = 1'b0;
        wait_neg(1);
        pin = 1'b1;
        wait_neg(2);
        chk("R8", "one-cycle low pulse kept", lvl_filt, 1'b0);
        wait_neg(12);
        chk("R8", "recovers high", lvl_filt, 1'b1);

        // R10: tick every third cycle, unit 2, count 2 -> 4 ticks in 10..12 edges
        settle_low();
        tick_div = 3;
        mode = 2'd1; coarse = 1'b0; step = 1'b0; cnt = 4'd2;
        wait_neg(4);
        pin = 1'b1;
        wait_neg(11);
        chk("R10", "only three ticks seen", lvl_filt, 1'b0);
        wait_neg(3);
        chk("R10", "fourth tick accepted", lvl_filt, 1'b1);
        tick_div = 1;

        // R2: reset in the middle clears a high filtered level
        rst_n = 1'b0;
        #1;
        chk("R2", "async clear of filt", lvl_filt, 1'b0);
        wait_neg(2);
        rst_n = 1'b1;
        pin   = 1'b0;
        wait_neg(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule